// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at a root port and gathers the error messages that arrive from the hierarchy below it. Each message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester source ID. The block keeps a root status word that records which classes of error arrived, whether more than one arrived in a class, and whether the first uncorrectable error was fatal. It also stores the source ID of the first correctable and the first uncorrectable error. Software owns a three-bit root command register that enables interrupts per class. Software clears status bits by writing ones.

The interrupt has two forms. With message interrupts off, a level line follows the enabled condition: the received bits mapped onto the command enables and ANDed with them. With message interrupts on, a one-cycle request pulse carries the stored vector number. It fires only when the enabled condition turns from false to true, either through a new message or through a command write. The vector number is loaded by device-specific logic and cannot be written by software.

Top module: `root_err_collector`

## Requirements
- R1: After reset the root command, status, both source fields, `irq_level` and `msi_req` are all zero.
- R2: A correctable message (`msg_sev` = 0) sets status bit 0. If bit 0 was already set, it sets bit 1 (multiple correctable) and leaves `cor_src` unchanged. Otherwise it loads `cor_src` with `msg_src`.
- R3: A non-fatal message (`msg_sev` = 1) sets status bit 5. A fatal message (`msg_sev` = 2) sets bit 6. A fatal message also sets bit 4 (first fatal), but only if status bit 2 was clear before it.
- R4: A non-fatal or fatal message sets status bit 2 (uncorrectable received). If bit 2 was already set, it sets bit 3 (multiple uncorrectable) and keeps `uncor_src`. Otherwise it loads `uncor_src` with `msg_src`.
- R5: A message with `msg_sev` = 3 changes neither the status nor the source fields, and raises no interrupt.
- R6: With `msi_en` high, a message raises `msi_req` for exactly one cycle, in the cycle after the message, only if two things hold. The command bit at index `msg_sev` must be set (bit 0 correctable, bit 1 non-fatal, bit 2 fatal). The enabled condition must have been false before the message.
- R7: With `msi_en` low, `irq_level` equals the OR of ({status bit 6, bit 5, bit 0} AND root command). It follows command writes and status changes in the same cycle as the register update, and `msi_req` stays low. With `msi_en` high, `irq_level` is low.
- R8: With `msi_en` high, a command write raises `msi_req` only when the enabled condition is false under the old command and true under the written value.
- R9: `msi_vec` shows the vector loaded through `vec_we`/`vec_din`. No other input changes it.
- R10: Status bits are write-one-to-clear through `sts_clr_we`/`sts_clr_mask`. When a clear and a message arrive in the same cycle, the clear applies first, and the message is then judged against the cleared status.
- R11: `cmd_we` loads `root_cmd` with `cmd_wdata`. Without `cmd_we` the command holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_src | input | 16 | Requester source ID of the message |
| cmd_we | input | 1 | Root command write strobe |
| cmd_wdata | input | 3 | Root command write data (correctable, non-fatal, fatal enables) |
| sts_clr_we | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask | input | 7 | Bits to clear in the status word |
| msi_en | input | 1 | Message interrupts enabled |
| vec_we | input | 1 | Load strobe for the interrupt vector number |
| vec_din | input | 5 | Interrupt vector number to load |
| root_cmd | output | 3 | Root command register |
| root_sts | output | 7 | Status: 0 cor, 1 multi cor, 2 uncor, 3 multi uncor, 4 first fatal, 5 non-fatal, 6 fatal |
| cor_src | output | 16 | Source ID of the first correctable error |
| uncor_src | output | 16 | Source ID of the first uncorrectable error |
| irq_level | output | 1 | Level interrupt when message interrupts are off |
| msi_req | output | 1 | One-cycle message interrupt request |
| msi_vec | output | 5 | Vector number sent with the request |

## Verification
Repeated correctable messages, and a non-fatal message followed by a fatal one, separate first-receipt capture from multiple-receipt marking. A fatal message into clean status shows that first-fatal depends on prior uncorrectable history. Command writes toward an already-true condition, toward false, and then back to true separate edge-triggered message requests from the level line. A clear that coincides with a message checks that the cleared state, not the stale one, governs source capture and the interrupt.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_RSVD     = 2'd3
  } sev_e;

  localparam int STS_W = 7;
  localparam int CMD_W = 3;

  localparam int ST_COR      = 0;
  localparam int ST_MULTI_COR = 1;
  localparam int ST_UNC      = 2;
  localparam int ST_MULTI_UNC = 3;
  localparam int ST_FIRST_FAT = 4;
  localparam int ST_NONFATAL = 5;
  localparam int ST_FATAL    = 6;

  // received bits of the status word mapped onto command enable positions
  function automatic logic [CMD_W-1:0] rcv_to_en(input logic [STS_W-1:0] s);
    return {s[ST_FATAL], s[ST_NONFATAL], s[ST_COR]};
  endfunction
endpackage

// File: rtl/rec_status_upd.sv
module rec_status_upd
  import rec_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic [STS_W-1:0] sts_q,
  input  logic [STS_W-1:0] clr_mask,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic [SRC_W-1:0] cor_src_q,
  input  logic [SRC_W-1:0] unc_src_q,
  output logic [STS_W-1:0] eff_sts,
  output logic [STS_W-1:0] sts_d,
  output logic [SRC_W-1:0] cor_src_d,
  output logic [SRC_W-1:0] unc_src_d
);
  logic is_cor, is_unc, is_fat;

  always_comb begin
    is_cor = msg_valid && (msg_sev == SEV_COR);
    is_fat = msg_valid && (msg_sev == SEV_FATAL);
    is_unc = msg_valid && ((msg_sev == SEV_NONFATAL) || (msg_sev == SEV_FATAL));
  end

  always_comb begin
    eff_sts   = sts_q & ~clr_mask;
    sts_d     = eff_sts;
    cor_src_d = cor_src_q;
    unc_src_d = unc_src_q;

    if (is_cor) begin
      if (eff_sts[ST_COR]) sts_d[ST_MULTI_COR] = 1'b1;
      else                 cor_src_d = msg_src;
      sts_d[ST_COR] = 1'b1;
    end

    if (is_unc) begin
      if (msg_sev == SEV_NONFATAL) sts_d[ST_NONFATAL] = 1'b1;
      if (is_fat) begin
        if (!eff_sts[ST_UNC]) sts_d[ST_FIRST_FAT] = 1'b1;
        sts_d[ST_FATAL] = 1'b1;
      end
      if (eff_sts[ST_UNC]) sts_d[ST_MULTI_UNC] = 1'b1;
      else                 unc_src_d = msg_src;
      sts_d[ST_UNC] = 1'b1;
    end
  end
endmodule

// File: rtl/rec_irq_gen.sv
module rec_irq_gen
  import rec_pkg::*;
(
  input  logic [STS_W-1:0] sts_q,
  input  logic [STS_W-1:0] eff_sts,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic             msi_en,
  output logic             irq_level,
  output logic             msi_fire
);
  logic [CMD_W-1:0] sev_hot;
  logic [CMD_W-1:0] cond_now;
  logic [CMD_W-1:0] cond_eff_old;
  logic [CMD_W-1:0] cond_eff_new;
  logic             msg_fire, cmd_fire;

  always_comb begin
    sev_hot      = msg_valid ? (CMD_W'(1) << msg_sev) : '0;
    cond_now     = rcv_to_en(sts_q) & cmd_q;
    cond_eff_old = rcv_to_en(eff_sts) & cmd_q;
    cond_eff_new = rcv_to_en(eff_sts) & cmd_wdata;
    irq_level    = !msi_en && (|cond_now);
    msg_fire     = (|(sev_hot & cmd_q)) && !(|cond_eff_old);
    cmd_fire     = cmd_we && !(|cond_eff_old) && (|cond_eff_new);
    msi_fire     = msi_en && (msg_fire || cmd_fire);
  end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             sts_clr_we,
  input  logic [STS_W-1:0] sts_clr_mask,
  input  logic             msi_en,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_din,
  output logic [CMD_W-1:0] root_cmd,
  output logic [STS_W-1:0] root_sts,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] uncor_src,
  output logic             irq_level,
  output logic             msi_req,
  output logic [VEC_W-1:0] msi_vec
);
  logic [STS_W-1:0] sts_q, sts_d, eff_sts, clr_mask;
  logic [SRC_W-1:0] cor_q, cor_d, unc_q, unc_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             msi_q, msi_fire;

  always_comb begin
    clr_mask = sts_clr_we ? sts_clr_mask : '0;
    cmd_d    = cmd_we ? cmd_wdata : cmd_q;
    vec_d    = vec_we ? vec_din : vec_q;
  end

  rec_status_upd #(.SRC_W(SRC_W)) u_upd (
    .sts_q     (sts_q),
    .clr_mask  (clr_mask),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .msg_src   (msg_src),
    .cor_src_q (cor_q),
    .unc_src_q (unc_q),
    .eff_sts   (eff_sts),
    .sts_d     (sts_d),
    .cor_src_d (cor_d),
    .unc_src_d (unc_d)
  );

  rec_irq_gen u_irq (
    .sts_q     (sts_q),
    .eff_sts   (eff_sts),
    .cmd_q     (cmd_q),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .msi_en    (msi_en),
    .irq_level (irq_level),
    .msi_fire  (msi_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      cor_q <= '0;
      unc_q <= '0;
      cmd_q <= '0;
      vec_q <= '0;
      msi_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      cor_q <= cor_d;
      unc_q <= unc_d;
      cmd_q <= cmd_d;
      vec_q <= vec_d;
      msi_q <= msi_fire;
    end
  end

  assign root_cmd  = cmd_q;
  assign root_sts  = sts_q;
  assign cor_src   = cor_q;
  assign uncor_src = unc_q;
  assign msi_req   = msi_q;
  assign msi_vec   = vec_q;

  // R2: repeat correctable marks multiple
  a_r2_multi_cor: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_COR && root_sts[ST_COR] && !clr_mask[ST_COR])
      |=> root_sts[ST_MULTI_COR] && $stable(cor_src));
  // R4: repeat uncorrectable keeps the first source
  a_r4_keep_unc_src: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL) &&
     root_sts[ST_UNC] && !clr_mask[ST_UNC])
      |=> root_sts[ST_MULTI_UNC] && $stable(uncor_src));
  // R5: reserved severity ignored
  a_r5_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_RSVD && !sts_clr_we)
      |=> $stable(root_sts) && $stable(cor_src) && $stable(uncor_src));
  // R6: requests only in message interrupt mode
  a_r6_msi_mode: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msi_en));
  // R7: level line silent when message interrupts enabled
  a_r7_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !irq_level);
  // R11: command holds without a write
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(root_cmd));
endmodule

// File: tb/root_err_collector_test.sv
module root_err_collector_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;
  logic        cmd_we;
  logic [2:0]  cmd_wdata;
  logic        sts_clr_we;
  logic [6:0]  sts_clr_mask;
  logic        msi_en, vec_we;
  logic [4:0]  vec_din;
  logic [2:0]  root_cmd;
  logic [6:0]  root_sts;
  logic [15:0] cor_src, uncor_src;
  logic        irq_level, msi_req;
  logic [4:0]  msi_vec;

  int n_run = 0;
  int n_fail = 0;

  root_err_collector uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .msi_en(msi_en),
    .vec_we(vec_we), .vec_din(vec_din), .root_cmd(root_cmd),
    .root_sts(root_sts), .cor_src(cor_src), .uncor_src(uncor_src),
    .irq_level(irq_level), .msi_req(msi_req), .msi_vec(msi_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one message for one cycle; returns at the following negedge
  task automatic send(input logic [1:0] sev, input logic [15:0] src);
    msg_valid = 1'b1; msg_sev = sev; msg_src = src;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr_cmd(input logic [2:0] v);
    cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic clr(input logic [6:0] m);
    sts_clr_we = 1'b1; sts_clr_mask = m;
    @(negedge clk);
    sts_clr_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cmd", root_cmd, 0);
    chk("R1 sts", root_sts, 0);
    chk("R1 cor_src", cor_src, 0);
    chk("R1 uncor_src", uncor_src, 0);
    chk("R1 irq", irq_level, 0);
    chk("R1 msi", msi_req, 0);
  endtask

  task automatic t_cor;
    send(2'd0, 16'h1111);
    chk("R2 first sts", root_sts, 7'h01);
    chk("R2 first src", cor_src, 16'h1111);
    send(2'd0, 16'h2222);
    chk("R2 multi sts", root_sts, 7'h03);
    chk("R2 src kept", cor_src, 16'h1111);
  endtask

  task automatic t_uncor;
    send(2'd1, 16'h3333);
    chk("R3 nonfatal sts", root_sts, 7'h27);
    chk("R4 first unc src", uncor_src, 16'h3333);
    send(2'd2, 16'h4444);
    chk("R3 fatal no first-fatal", root_sts, 7'h6F);
    chk("R4 unc src kept", uncor_src, 16'h3333);
    clr(7'h7F);
    chk("R10 clear all", root_sts, 7'h00);
    send(2'd2, 16'h5555);
    chk("R3 first fatal", root_sts, 7'h54);
    chk("R4 fatal src", uncor_src, 16'h5555);
  endtask

  task automatic t_rsvd;
    send(2'd3, 16'h6666);
    chk("R5 sts", root_sts, 7'h54);
    chk("R5 cor_src", cor_src, 16'h1111);
    chk("R5 uncor_src", uncor_src, 16'h5555);
    chk("R5 irq", irq_level, 0);
    clr(7'h7F);
  endtask

  task automatic t_level;
    wr_cmd(3'b001);
    chk("R11 cmd write", root_cmd, 3'b001);
    chk("R7 no cond", irq_level, 0);
    send(2'd0, 16'h0AAA);
    chk("R7 level up", irq_level, 1);
    chk("R7 no msi", msi_req, 0);
    wr_cmd(3'b000);
    chk("R7 level down by cmd", irq_level, 0);
    wr_cmd(3'b001);
    chk("R7 level up by cmd", irq_level, 1);
    chk("R7 no msi on cmd", msi_req, 0);
    clr(7'h03);
    chk("R7 level down by clear", irq_level, 0);
  endtask

  task automatic t_msi_msg;
    msi_en = 1'b1;
    vec_we = 1'b1; vec_din = 5'd9;
    @(negedge clk);
    vec_we = 1'b0; vec_din = 5'd3;
    chk("R9 vec loaded", msi_vec, 5'd9);
    wr_cmd(3'b010);
    send(2'd0, 16'h0B0B);
    chk("R6 disabled class", msi_req, 0);
    send(2'd1, 16'h0C0C);
    chk("R6 pulse", msi_req, 1);
    chk("R9 vec sent", msi_vec, 5'd9);
    chk("R7 level off in msi", irq_level, 0);
    @(negedge clk);
    chk("R6 one cycle", msi_req, 0);
    send(2'd1, 16'h0D0D);
    chk("R6 already true", msi_req, 0);
  endtask

  task automatic t_cmd_edge;
    wr_cmd(3'b011);
    chk("R8 already true", msi_req, 0);
    wr_cmd(3'b000);
    chk("R8 to false", msi_req, 0);
    wr_cmd(3'b001);
    chk("R8 rising", msi_req, 1);
    @(negedge clk);
    chk("R8 one cycle", msi_req, 0);
  endtask

  task automatic t_collide;
    clr(7'h7F);
    send(2'd0, 16'h1234);
    @(negedge clk);
    chk("R10 setup sts", root_sts, 7'h01);
    sts_clr_we = 1'b1; sts_clr_mask = 7'h03;
    send(2'd0, 16'h7777);
    sts_clr_we = 1'b0;
    chk("R10 msg wins sts", root_sts, 7'h01);
    chk("R10 fresh src", cor_src, 16'h7777);
    chk("R10 msi after clear", msi_req, 1);
  endtask

  initial begin
    rst_n = 1'b0; msg_valid = 0; msg_sev = 0; msg_src = 0;
    cmd_we = 0; cmd_wdata = 0; sts_clr_we = 0; sts_clr_mask = 0;
    msi_en = 0; vec_we = 0; vec_din = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cor;
    t_uncor;
    t_rsvd;
    t_level;
    t_msi_msg;
    t_cmd_edge;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule